// File: doc/BRIEF.md
# Iterative Restoring Step Divider

This block performs unsigned division as a series of short commands, not as one long operation. An initialise command loads a dividend and a divisor. It clears the quotient, copies the dividend into the remainder and applies one alignment subtraction. The divisor is shifted left so that its highest set bit sits under the highest set bit of the remainder. If it then overshoots, it is pulled back by one place. It is subtracted once, and the matching power of two is added to the quotient.

Each later step command supplies a low-order source word and a count of the source bits still to be consumed. While the working remainder is smaller than the divisor and bits are left, the step shifts source bit (count − 1) into the remainder, doubles the quotient and decrements the count. It then performs one alignment subtraction. The step returns the new count and raises an end flag when that count is zero. A step given a zero count does nothing, so a controller can issue a fixed, unrolled number of steps.

A full W-by-W division is run as an initialise with dividend 0 and the real divisor. Steps follow with the real dividend as source word, feeding each returned count into the next step until the end flag is seen. Two read commands then return the quotient and the remainder.

Top module: `sdiv_core`

## Requirements
- R1: After reset, the response outputs are 0, and the quotient, remainder and stored divisor are all 0.
- R2: Command codes on `cmd` are 0 idle, 1 initialise, 2 step, 3 read quotient and 4 read remainder. Codes 5 to 7 behave as idle. Every non-idle command gives a response with `rsp_valid` high on the clock edge that samples it. Idle gives `rsp_valid` low. `rsp_end` and `rsp_dz` are only ever high together with `rsp_valid`.
- R3: Initialise with a nonzero divisor (`opnd_a` = dividend, `opnd_b` = divisor) sets quotient 0 and remainder = dividend, then performs one alignment subtraction. It stores the divisor and responds with data 0. For example, 100/7 leaves quotient 8 and remainder 44, and 200/1 leaves 128 and 72.
- R4: When the divisor is larger than the value it is aligned against, the alignment subtraction changes nothing (initialise of 5 with divisor 9 leaves quotient 0 and remainder 5).
- R5: An initialise with divisor 0 raises `rsp_dz` and leaves the quotient, remainder and stored divisor unchanged. A step with a nonzero count while the stored divisor is 0 also raises `rsp_dz`, changes nothing, and returns its count with `rsp_end` low.
- R6: A step whose count (`opnd_b` bits [CW-1:0], CW = clog2(W+1)) is 0 changes nothing, returns 0 and raises `rsp_end`.
- R7: A step shifts source bits from `opnd_a` into the remainder, most significant remaining bit first, while the remainder is below the divisor and bits remain. Each shift doubles the quotient. The step then applies one alignment subtraction and returns the new count in `rsp_data`, with `rsp_end` high when that count is 0. For example, with remainder 0, divisor 3 and source 0xB4 at count 8, the step returns 5 and leaves quotient 1 and remainder 2.
- R8: A step count above W is treated as W.
- R9: Read quotient and read remainder return the stored registers in `rsp_data` and change nothing.
- R10: The full sequence described above yields floor(a/b) and a mod b for every dividend and nonzero divisor, in at most W steps.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd | input | 3 | Command code |
| opnd_a | input | W | Dividend (initialise) or source word (step) |
| opnd_b | input | W | Divisor (initialise) or remaining count (step) |
| rsp_valid | output | 1 | Response present this cycle |
| rsp_data | output | W | Count left, quotient or remainder |
| rsp_end | output | 1 | Step finished with zero bits left |
| rsp_dz | output | 1 | Divide-by-zero error |

## Verification
An 8-bit instance runs the complete sequence for every dividend against a set of divisors: 1 and 255 (the extremes of the quotient), powers of two and their neighbours (alignment with and without the one-place pullback), and odd values (multi-bit remainders). A 64-bit instance runs pseudo-random pairs plus all-ones operands, a top-bit divisor, and dividend below divisor, which separate width-dependent alignment from the small case. Single commands with hand-computed results pin down the initialise subtraction, the shift-in loop, count saturation, the zero-count no-op and both divide-by-zero paths.

// File: rtl/sdiv_pkg.sv
package sdiv_pkg;
  typedef enum logic [2:0] {
    CMD_IDLE = 3'd0,
    CMD_INIT = 3'd1,
    CMD_STEP = 3'd2,
    CMD_RDQ  = 3'd3,
    CMD_RDR  = 3'd4
  } sdiv_cmd_e;
endpackage

// File: rtl/sdiv_align.sv
// One alignment subtraction: line the divisor up with the value's top bit,
// step back one place on overshoot, subtract once and credit the quotient.
module sdiv_align #(
  parameter int W = 64
) (
  input  logic [W:0]   rem_i,
  input  logic [W-1:0] div_i,
  input  logic [W-1:0] quo_i,
  output logic [W-1:0] rem_o,
  output logic [W-1:0] quo_o,
  output logic         fire_o
);
  localparam int IW = $clog2(W + 1) + 1;

  function automatic logic [IW-1:0] top_bit(input logic [W:0] v);
    logic [IW-1:0] p;
    p = '0;
    for (int i = 0; i <= W; i++) begin
      if (v[i]) p = IW'(i);
    end
    return p;
  endfunction

  logic [IW-1:0] sh;
  logic [W:0]    dsh;
  logic [W-1:0]  qb;

  always_comb begin
    fire_o = (div_i != '0) && ({1'b0, div_i} <= rem_i);
    sh     = top_bit(rem_i) - top_bit({1'b0, div_i});
    dsh    = {1'b0, div_i} << sh;
    qb     = W'(1) << sh;
    if (dsh > rem_i) begin
      dsh = dsh >> 1;
      qb  = qb >> 1;
    end
    if (fire_o) begin
      rem_o = rem_i[W-1:0] - dsh[W-1:0];
      quo_o = quo_i + qb;
    end else begin
      rem_o = rem_i[W-1:0];
      quo_o = quo_i;
    end
  end
endmodule

// File: rtl/sdiv_fill.sv
// Shift-in loop of a step: pull source bits into the remainder while it is
// below the divisor and bits remain; the quotient doubles per bit.
module sdiv_fill #(
  parameter int W  = 64,
  parameter int CW = 7
) (
  input  logic [W-1:0]  rem_i,
  input  logic [W-1:0]  div_i,
  input  logic [W-1:0]  quo_i,
  input  logic [W-1:0]  src_i,
  input  logic [CW-1:0] cnt_i,
  output logic [W:0]    wd_o,
  output logic [W-1:0]  quo_o,
  output logic [CW-1:0] cnt_o
);
  logic [CW-1:0] c;
  logic [W:0]    wd;
  logic [W-1:0]  q;
  logic          bit_in;

  always_comb begin
    c      = (cnt_i > CW'(W)) ? CW'(W) : cnt_i;
    wd     = {1'b0, rem_i};
    q      = quo_i;
    bit_in = 1'b0;
    for (int k = 0; k < W; k++) begin
      if ((wd < {1'b0, div_i}) && (c != '0)) begin
        bit_in = |(src_i & (W'(1) << (c - 1'b1)));
        wd     = {wd[W-1:0], bit_in};
        q      = {q[W-2:0], 1'b0};
        c      = c - 1'b1;
      end
    end
    wd_o  = wd;
    quo_o = q;
    cnt_o = c;
  end
endmodule

// File: rtl/sdiv_core.sv
module sdiv_core
  import sdiv_pkg::*;
#(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [2:0]   cmd,
  input  logic [W-1:0] opnd_a,
  input  logic [W-1:0] opnd_b,
  output logic         rsp_valid,
  output logic [W-1:0] rsp_data,
  output logic         rsp_end,
  output logic         rsp_dz
);
  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  q_r, r_r, d_r;
  logic [CW-1:0] step_cnt;

  // named internal events
  logic ev_init, ev_step, ev_read, ev_dz, ev_step_act, ev_fire;

  logic [W:0]    fill_wd;
  logic [W-1:0]  fill_q;
  logic [CW-1:0] fill_cnt;
  logic [W:0]    al_rem_in;
  logic [W-1:0]  al_div_in, al_quo_in, al_rem, al_quo;

  assign step_cnt    = opnd_b[CW-1:0];
  assign ev_init     = (cmd == CMD_INIT);
  assign ev_step     = (cmd == CMD_STEP);
  assign ev_read     = (cmd == CMD_RDQ) || (cmd == CMD_RDR);
  assign ev_dz       = (ev_init && (opnd_b == '0)) ||
                       (ev_step && (d_r == '0) && (step_cnt != '0));
  assign ev_step_act = ev_step && (step_cnt != '0) && (d_r != '0);

  sdiv_fill #(.W(W), .CW(CW)) u_fill (
    .rem_i (r_r),
    .div_i (d_r),
    .quo_i (q_r),
    .src_i (opnd_a),
    .cnt_i (step_cnt),
    .wd_o  (fill_wd),
    .quo_o (fill_q),
    .cnt_o (fill_cnt)
  );

  assign al_rem_in = ev_init ? {1'b0, opnd_a} : fill_wd;
  assign al_div_in = ev_init ? opnd_b : d_r;
  assign al_quo_in = ev_init ? '0 : fill_q;

  sdiv_align #(.W(W)) u_align (
    .rem_i  (al_rem_in),
    .div_i  (al_div_in),
    .quo_i  (al_quo_in),
    .rem_o  (al_rem),
    .quo_o  (al_quo),
    .fire_o (ev_fire)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_r       <= '0;
      r_r       <= '0;
      d_r       <= '0;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
      rsp_end   <= 1'b0;
      rsp_dz    <= 1'b0;
    end else begin
      rsp_valid <= ev_init || ev_step || ev_read;
      rsp_dz    <= ev_dz;
      rsp_end   <= 1'b0;
      rsp_data  <= '0;
      if (ev_init && !ev_dz) begin
        q_r <= al_quo;
        r_r <= al_rem;
        d_r <= opnd_b;
      end
      if (ev_step) begin
        if (ev_step_act) begin
          q_r      <= al_quo;
          r_r      <= al_rem;
          rsp_data <= W'(fill_cnt);
          rsp_end  <= (fill_cnt == '0);
        end else if (ev_dz) begin
          rsp_data <= W'(step_cnt);
        end else begin
          rsp_end  <= 1'b1;
        end
      end
      if (cmd == CMD_RDQ) rsp_data <= q_r;
      if (cmd == CMD_RDR) rsp_data <= r_r;
    end
  end
endmodule

// File: rtl/sdiv_chk.sv
module sdiv_chk #(
  parameter int W  = 64,
  parameter int CW = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ev_init,
  input logic          ev_step,
  input logic          ev_dz,
  input logic [CW-1:0] step_cnt,
  input logic [W-1:0]  q_r,
  input logic [W-1:0]  r_r,
  input logic [W-1:0]  opnd_a,
  input logic [W-1:0]  opnd_b,
  input logic          rsp_valid,
  input logic [W-1:0]  rsp_data,
  input logic          rsp_end,
  input logic          rsp_dz
);
  logic [W-1:0] cnt_wide;
  assign cnt_wide = W'(step_cnt);

  assert_flag_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_end || rsp_dz) |-> rsp_valid);

  assert_init_resp_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_init && opnd_b != '0) |=> (rsp_valid && !rsp_dz && rsp_data == '0));

  assert_small_noop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_init && opnd_b != '0 && opnd_b > opnd_a) |=> (q_r == '0 && r_r == $past(opnd_a)));

  assert_dz_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_dz |=> (rsp_dz && $stable(q_r) && $stable(r_r)));

  assert_zero_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_step && step_cnt == '0) |=> (rsp_end && rsp_data == '0 && $stable(q_r) && $stable(r_r)));

  assert_cnt_shrink_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_step && !ev_dz && step_cnt != '0) |=> (rsp_data <= $past(cnt_wide)));
endmodule

bind sdiv_core sdiv_chk #(.W(W), .CW(CW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ev_init   (ev_init),
  .ev_step   (ev_step),
  .ev_dz     (ev_dz),
  .step_cnt  (step_cnt),
  .q_r       (q_r),
  .r_r       (r_r),
  .opnd_a    (opnd_a),
  .opnd_b    (opnd_b),
  .rsp_valid (rsp_valid),
  .rsp_data  (rsp_data),
  .rsp_end   (rsp_end),
  .rsp_dz    (rsp_dz)
);

// File: tb/tb_sdiv_core.sv
module tb_sdiv_core;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  int tests = 0;
  int fails = 0;

  logic [2:0]  c8 = 3'd0;
  logic [7:0]  a8 = '0, b8 = '0;
  logic        v8, e8, z8;
  logic [7:0]  d8;

  logic [2:0]  c64 = 3'd0;
  logic [63:0] a64 = '0, b64 = '0;
  logic        v64, e64, z64;
  logic [63:0] d64;

  sdiv_core #(.W(8)) dut (
    .clk(clk), .rst_n(rst_n), .cmd(c8), .opnd_a(a8), .opnd_b(b8),
    .rsp_valid(v8), .rsp_data(d8), .rsp_end(e8), .rsp_dz(z8));

  sdiv_core #(.W(64)) dut64 (
    .clk(clk), .rst_n(rst_n), .cmd(c64), .opnd_a(a64), .opnd_b(b64),
    .rsp_valid(v64), .rsp_data(d64), .rsp_end(e64), .rsp_dz(z64));

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // drive at a falling edge; response is sampled at the next falling edge
  task automatic do8(input logic [2:0] c, input logic [7:0] a, input logic [7:0] b);
    c8 = c; a8 = a; b8 = b;
    @(negedge clk);
    c8 = 3'd0;
  endtask

  task automatic do64(input logic [2:0] c, input logic [63:0] a, input logic [63:0] b);
    c64 = c; a64 = a; b64 = b;
    @(negedge clk);
    c64 = 3'd0;
  endtask

  // R10: full sequence on the 8-bit instance
  task automatic div8(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] cnt;
    logic fin;
    int nsteps;
    cnt = 8'd8; fin = 1'b0; nsteps = 0;
    do8(3'd1, 8'd0, b);
    for (int k = 0; k < 10; k++) begin
      if (!fin) begin
        do8(3'd2, a, cnt);
        cnt = d8; fin = e8; nsteps++;
      end
    end
    chk("R10 finish within W steps", {63'd0, fin && nsteps <= 8}, 64'd1);
    do8(3'd3, 8'd0, 8'd0);
    chk("R10 quotient w8", {56'd0, d8}, {56'd0, a / b});
    do8(3'd4, 8'd0, 8'd0);
    chk("R10 remainder w8", {56'd0, d8}, {56'd0, a % b});
  endtask

  task automatic div64(input logic [63:0] a, input logic [63:0] b);
    logic [63:0] cnt;
    logic fin;
    int nsteps;
    cnt = 64'd64; fin = 1'b0; nsteps = 0;
    do64(3'd1, 64'd0, b);
    for (int k = 0; k < 66; k++) begin
      if (!fin) begin
        do64(3'd2, a, cnt);
        cnt = d64; fin = e64; nsteps++;
      end
    end
    chk("R10 finish within W steps w64", {63'd0, fin && nsteps <= 64}, 64'd1);
    do64(3'd3, 64'd0, 64'd0);
    chk("R10 quotient w64", d64, a / b);
    do64(3'd4, 64'd0, 64'd0);
    chk("R10 remainder w64", d64, a % b);
  endtask

  initial begin
    #1_500_000;
    tests++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [63:0] x;
    logic [7:0] dset [10];
    dset = '{8'd1, 8'd2, 8'd3, 8'd5, 8'd7, 8'd16, 8'd127, 8'd128, 8'd200, 8'd255};

    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 valid after reset", {63'd0, v8}, 64'd0);
    chk("R1 end/dz after reset", {62'd0, e8, z8}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    do8(3'd3, 8'd0, 8'd0);
    chk("R1 quotient reset", {56'd0, d8}, 64'd0);
    chk("R9 read valid", {63'd0, v8}, 64'd1);
    do8(3'd4, 8'd0, 8'd0);
    chk("R1 remainder reset", {56'd0, d8}, 64'd0);

    // R5: step with stored divisor zero (divisor is 0 after reset)
    do8(3'd2, 8'hFF, 8'd3);
    chk("R5 dz on step", {63'd0, z8}, 64'd1);
    chk("R5 step count returned", {55'd0, e8, d8}, 64'd3);

    // R2: idle and unused codes
    do8(3'd0, 8'd0, 8'd0);
    chk("R2 idle no valid", {63'd0, v8}, 64'd0);
    do8(3'd7, 8'd1, 8'd1);
    chk("R2 unused code no valid", {63'd0, v8}, 64'd0);

    // R3: initialise with alignment pullback
    do8(3'd1, 8'd100, 8'd7);
    chk("R3 init response", {55'd0, z8, d8}, 64'd0);
    do8(3'd3, 8'd0, 8'd0);
    chk("R3 quotient 100/7", {56'd0, d8}, 64'd8);
    do8(3'd4, 8'd0, 8'd0);
    chk("R3 remainder 100/7", {56'd0, d8}, 64'd44);
    do8(3'd1, 8'd200, 8'd1);
    do8(3'd3, 8'd0, 8'd0);
    chk("R3 quotient 200/1", {56'd0, d8}, 64'd128);
    do8(3'd4, 8'd0, 8'd0);
    chk("R3 remainder 200/1", {56'd0, d8}, 64'd72);

    // R5: divide by zero on initialise keeps state (still 128/72)
    do8(3'd1, 8'd50, 8'd0);
    chk("R5 dz on init", {63'd0, z8}, 64'd1);
    do8(3'd3, 8'd0, 8'd0);
    chk("R5 quotient kept", {56'd0, d8}, 64'd128);
    do8(3'd4, 8'd0, 8'd0);
    chk("R5 remainder kept", {56'd0, d8}, 64'd72);

    // R4: divisor above dividend
    do8(3'd1, 8'd5, 8'd9);
    do8(3'd3, 8'd0, 8'd0);
    chk("R4 quotient unchanged", {56'd0, d8}, 64'd0);
    do8(3'd4, 8'd0, 8'd0);
    chk("R4 remainder unchanged", {56'd0, d8}, 64'd5);

    // R7: single step with shift-in
    do8(3'd1, 8'd0, 8'd3);
    do8(3'd2, 8'hB4, 8'd8);
    chk("R7 count returned", {55'd0, e8, d8}, 64'd5);
    do8(3'd3, 8'd0, 8'd0);
    chk("R7 quotient after step", {56'd0, d8}, 64'd1);
    do8(3'd4, 8'd0, 8'd0);
    chk("R7 remainder after step", {56'd0, d8}, 64'd2);

    // R6: zero-count step is a no-op
    do8(3'd2, 8'hFF, 8'd0);
    chk("R6 end and data", {55'd0, e8, d8}, 64'h100);
    do8(3'd4, 8'd0, 8'd0);
    chk("R6 remainder untouched", {56'd0, d8}, 64'd2);
    do8(3'd3, 8'd0, 8'd0);
    chk("R6 quotient untouched", {56'd0, d8}, 64'd1);

    // R8: count 15 saturates to 8
    do8(3'd1, 8'd0, 8'd3);
    do8(3'd2, 8'hB4, 8'd15);
    chk("R8 saturated count", {55'd0, e8, d8}, 64'd5);

    // R10: sweep on the 8-bit instance
    for (int bi = 0; bi < 10; bi++) begin
      for (int a = 0; a < 256; a++) begin
        div8(8'(a), dset[bi]);
      end
    end

    // R10: 64-bit corners and pseudo-random pairs
    div64(64'hFFFF_FFFF_FFFF_FFFF, 64'd1);
    div64(64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF);
    div64(64'hFFFF_FFFF_FFFF_FFFE, 64'h8000_0000_0000_0000);
    div64(64'd12345, 64'hDEAD_BEEF_0000_0001);
    div64(64'd0, 64'd7);
    x = 64'h9E37_79B9_7F4A_7C15;
    for (int n = 0; n < 300; n++) begin
      logic [63:0] aa, bb;
      x = x ^ (x << 13); x = x ^ (x >> 7); x = x ^ (x << 17);
      aa = x;
      x = x ^ (x << 13); x = x ^ (x >> 7); x = x ^ (x << 17);
      bb = x >> (n % 64);
      if (bb == 64'd0) bb = 64'd3;
      div64(aa, bb);
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule